// File: doc/BRIEF.md
# External Memory Strobe Pulse Timer

This block generates the active-low chip-select, read-strobe and write-strobe pulses for an external static memory with three chip selects. Each chip select owns one 32-bit pulse-timing register. The register holds four 7-bit duration fields, and software loads it over a simple register bus. A write-protect input can lock all of these registers against change.

A requester presents a read or write for one chip select. The sequencer accepts it when idle and pulls the chip select and the matching strobe low on the next cycle. It holds each line low for the length decoded from that chip select's fields. When the longer pulse has ended, it raises a one-cycle done pulse. In page-mode reads, the first access to a page uses the chip-select read duration. Each later access to the same page uses the read-strobe duration, and this applies to both lines. Setup, hold, cycle timing and the data and address pins are handled elsewhere.

Top module: `strobe_pulse_timer`

## Requirements
- R1: After reset, the register of chip select x (byte offset 0x04 + 0x10*x, x = 0..2) reads 0x01010101. A read at any other offset returns zero.
- R2: A register write stores bits 30:24 (chip-select read duration), 22:16 (read-strobe duration), 14:8 (chip-select write duration) and 6:0 (write-strobe duration). Bits 31, 23, 15 and 7 always read back as zero.
- R3: While `wrProtect` is high, a register write changes no register contents.
- R4: A field f decodes to 256*f[6] + f[5:0] clock cycles. A field that decodes to zero gives one cycle.
- R5: In a standard read, the selected `csN` line is low for the chip-select read duration and `rdN` is low for the read-strobe duration. Both go low in the cycle after acceptance, and `weN` stays high.
- R6: In a write, the selected `csN` line is low for the chip-select write duration and `weN` is low for the write-strobe duration. Both go low in the cycle after acceptance, and `rdN` stays high.
- R7: In a page-mode read that misses, both `csN` and `rdN` are low for the chip-select read duration. In a page-mode read that hits, both are low for the read-strobe duration.
- R8: A page hit requires `reqPage`, an open page, the same chip select as the previous read, and equal address bits above bit PAGE_BITS-1. A write, a standard read, or a page read to another chip select closes the page or moves it.
- R9: A request is accepted only when `reqValid` is high, `busy` is low and `reqCs` is below 3. `busy` is high from the cycle after acceptance until the access ends, and requests made while busy are dropped. `done` is high for exactly one cycle, the first cycle after the longer pulse ends, and `busy` is low in that cycle.
- R10: At most one `csN` line is low at a time, and `rdN` and `weN` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| wrProtect | input | 1 | Blocks register writes when high |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPage | input | 1 | Page-mode read enable |
| reqCs | input | 2 | Chip select index |
| reqAddr | input | 16 | Access address (used for page matching) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| csN | output | 3 | Active-low chip selects |
| rdN | output | 1 | Active-low read strobe |
| weN | output | 1 | Active-low write strobe |

## Verification
The bench programs fields that exercise the 256-cycle top bit, the all-zero field and unequal chip-select and strobe lengths. A decoder that treats the field as plain binary, or that lets a zero field give no pulse, would produce the wrong low-cycle counts. Page sequences cover a hit, a miss on a new page, a close caused by a write, and a close caused by a change of chip select. A sequencer that ignores any of these conditions would choose the wrong duration for the access. Requests made while busy and requests to chip select 3 are checked to start no access, and a write made under protection must leave the readback unchanged.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int FIELD_W = 7;
  localparam int LEN_W   = 9;

  // Strobes from the sequencer control to the timing datapath.
  typedef struct packed {
    logic load;     // start a new access this cycle
    logic isWrite;  // write access
    logic usePage;  // page-mode read
    logic pageHit;  // page-mode read hits the open page
  } seqCtrl_t;

  // Split encoding: top bit worth 256 cycles, low six bits single cycles.
  function automatic logic [LEN_W-1:0] decodeLen(input logic [FIELD_W-1:0] f);
    logic [LEN_W-1:0] len;
    len = {f[FIELD_W-1], 2'b00, f[FIELD_W-2:0]};
    if (len == '0) len = LEN_W'(1);
    return len;
  endfunction
endpackage

// File: rtl/spt_regs.sv
module spt_regs #(
  parameter int NUM_CS = 3,
  parameter int RA_W   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [RA_W-1:0]        regAddr,
  input  logic [31:0]            regWrData,
  input  logic                   wrProtect,
  output logic [31:0]            regRdData,
  output logic [NUM_CS-1:0][31:0] pulseRegs
);
  localparam logic [31:0] RESET_VAL  = 32'h0101_0101;
  localparam logic [31:0] FIELD_MASK = 32'h7F7F_7F7F;

  logic [NUM_CS-1:0] addrHit;

  genvar gx;
  generate
    for (gx = 0; gx < NUM_CS; gx++) begin : g_dec
      localparam int OFFS = 4 + 16 * gx;
      assign addrHit[gx] = (regAddr == RA_W'(OFFS));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CS; i++) pulseRegs[i] <= RESET_VAL;
    end else if (regWr && !wrProtect) begin
      for (int i = 0; i < NUM_CS; i++)
        if (addrHit[i]) pulseRegs[i] <= regWrData & FIELD_MASK;
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (addrHit[i]) regRdData = pulseRegs[i];
  end
endmodule

// File: rtl/spt_datapath.sv
module spt_datapath
  import spt_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int CS_W   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqCtrl_t                ctrl,
  input  logic [CS_W-1:0]         reqCs,
  input  logic [NUM_CS-1:0][31:0] pulseRegs,
  output logic [NUM_CS-1:0]       csN,
  output logic                    rdN,
  output logic                    weN,
  output logic                    nearEnd
);
  logic [31:0]        selReg;
  logic [FIELD_W-1:0] fCsRd, fRd, fCsWr, fWe;
  logic [LEN_W-1:0]   loadCs, loadSt;
  logic [LEN_W-1:0]   csCnt, stCnt;
  logic [CS_W-1:0]    curCs;
  logic               curWr;
  logic               unusedRsvd;

  always_comb begin
    selReg = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (reqCs == CS_W'(i)) selReg = pulseRegs[i];
  end

  assign fCsRd = selReg[30:24];
  assign fRd   = selReg[22:16];
  assign fCsWr = selReg[14:8];
  assign fWe   = selReg[6:0];
  assign unusedRsvd = selReg[31] ^ selReg[23] ^ selReg[15] ^ selReg[7];

  always_comb begin
    if (ctrl.isWrite) begin
      loadCs = decodeLen(fCsWr);
      loadSt = decodeLen(fWe);
    end else if (ctrl.usePage) begin
      loadCs = ctrl.pageHit ? decodeLen(fRd) : decodeLen(fCsRd);
      loadSt = loadCs;
    end else begin
      loadCs = decodeLen(fCsRd);
      loadSt = decodeLen(fRd);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csCnt <= '0;
      stCnt <= '0;
      curCs <= '0;
      curWr <= 1'b0;
    end else if (ctrl.load) begin
      csCnt <= loadCs;
      stCnt <= loadSt;
      curCs <= reqCs;
      curWr <= ctrl.isWrite;
    end else begin
      if (csCnt != '0) csCnt <= csCnt - LEN_W'(1);
      if (stCnt != '0) stCnt <= stCnt - LEN_W'(1);
    end
  end

  assign nearEnd = (csCnt <= LEN_W'(1)) && (stCnt <= LEN_W'(1));

  genvar gx;
  generate
    for (gx = 0; gx < NUM_CS; gx++) begin : g_cs
      assign csN[gx] = !((csCnt != '0) && (curCs == CS_W'(gx)));
    end
  endgenerate

  assign rdN = !((stCnt != '0) && !curWr);
  assign weN = !((stCnt != '0) && curWr);
endmodule

// File: rtl/spt_control.sv
module spt_control
  import spt_pkg::*;
#(
  parameter int NUM_CS    = 3,
  parameter int CS_W      = 2,
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqPage,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              nearEnd,
  output seqCtrl_t          ctrl,
  output logic              busy,
  output logic              done
);
  localparam int TAG_W = ADDR_W - PAGE_BITS;

  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t        state;
  logic             accept;
  logic             pageOpen;
  logic [CS_W-1:0]  pageCs;
  logic [TAG_W-1:0] pageTag;
  logic [TAG_W-1:0] reqTag;
  logic             hit;
  logic             unusedAddrBits;

  assign reqTag         = reqAddr[ADDR_W-1:PAGE_BITS];
  assign unusedAddrBits = ^reqAddr[PAGE_BITS-1:0];

  assign accept = reqValid && (state == ST_IDLE) && (32'(reqCs) < NUM_CS);
  assign hit    = reqPage && !reqWrite && pageOpen &&
                  (reqCs == pageCs) && (reqTag == pageTag);

  always_comb begin
    ctrl.load    = accept;
    ctrl.isWrite = reqWrite;
    ctrl.usePage = reqPage && !reqWrite;
    ctrl.pageHit = hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      pageOpen <= 1'b0;
      pageCs   <= '0;
      pageTag  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_RUN;
          pageOpen <= reqPage && !reqWrite;
          pageCs   <= reqCs;
          pageTag  <= reqTag;
        end
        ST_RUN: if (nearEnd) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/strobe_pulse_timer.sv
module strobe_pulse_timer
  import spt_pkg::*;
#(
  parameter int NUM_CS    = 3,
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 4,
  parameter int RA_W      = 8,
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS + 1) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [31:0]       regWrData,
  input  logic              wrProtect,
  output logic [31:0]       regRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqPage,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              busy,
  output logic              done,
  output logic [NUM_CS-1:0] csN,
  output logic              rdN,
  output logic              weN
);
  logic [NUM_CS-1:0][31:0] pulseRegs;
  seqCtrl_t                ctrl;
  logic                    nearEnd;

  spt_regs #(.NUM_CS(NUM_CS), .RA_W(RA_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .wrProtect(wrProtect),
    .regRdData(regRdData), .pulseRegs(pulseRegs)
  );

  spt_control #(.NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W),
                .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPage(reqPage), .reqCs(reqCs), .reqAddr(reqAddr),
    .nearEnd(nearEnd), .ctrl(ctrl), .busy(busy), .done(done)
  );

  spt_datapath #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqCs(reqCs),
    .pulseRegs(pulseRegs), .csN(csN), .rdN(rdN), .weN(weN),
    .nearEnd(nearEnd)
  );
endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
  parameter int NUM_CS = 3,
  parameter int CS_W   = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    regWr,
  input logic                    wrProtect,
  input logic                    reqValid,
  input logic [CS_W-1:0]         reqCs,
  input logic                    busy,
  input logic                    done,
  input logic [NUM_CS-1:0]       csN,
  input logic                    rdN,
  input logic                    weN,
  input logic [NUM_CS-1:0][31:0] pulseRegs
);
  // R10
  one_cs_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R10
  no_rd_we_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !weN));

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ((&csN) && rdN && weN));

  // R5
  start_next_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && (32'(reqCs) < NUM_CS)) |=> (busy && !(&csN)));

  // R3
  protect_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && wrProtect) |=> $stable(pulseRegs));
endmodule

bind strobe_pulse_timer spt_checker #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .wrProtect(wrProtect),
  .reqValid(reqValid), .reqCs(reqCs), .busy(busy), .done(done),
  .csN(csN), .rdN(rdN), .weN(weN), .pulseRegs(pulseRegs)
);

// File: tb/strobe_pulse_timer_tb.sv
module strobe_pulse_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        wrProtect = 1'b0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqPage = 1'b0;
  logic [1:0]  reqCs = '0;
  logic [15:0] reqAddr = '0;
  logic        busy, done, rdN, weN;
  logic [2:0]  csN;

  strobe_pulse_timer u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .wrProtect(wrProtect), .regRdData(regRdData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqPage(reqPage),
    .reqCs(reqCs), .reqAddr(reqAddr), .busy(busy), .done(done),
    .csN(csN), .rdN(rdN), .weN(weN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int    cs;
    int    csLen;
    int    stLen;
    bit    wr;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  task automatic checkEq(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int decLen(logic [6:0] f);
    int l;
    l = int'(f[6]) * 256 + int'(f[5:0]);
    return (l == 0) ? 1 : l;
  endfunction

  // Monitor: count low cycles per line, compare on done.
  int csCount = 0, rdCount = 0, weCount = 0, seenCs = -1;
  always @(negedge clk) begin
    if (rstN) begin
      for (int x = 0; x < 3; x++)
        if (!csN[x]) begin csCount++; seenCs = x; end
      if (!rdN) rdCount++;
      if (!weN) weCount++;
      if (done) begin
        if (expQ.size() == 0) begin
          checkEq("R9", "done without access", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          checkEq(e.tag, "chip select", seenCs, e.cs);
          checkEq(e.tag, "cs low cycles", csCount, e.csLen);
          if (e.wr) begin
            checkEq(e.tag, "we low cycles", weCount, e.stLen);
            checkEq("R10", "rd low during write", rdCount, 0);
          end else begin
            checkEq(e.tag, "rd low cycles", rdCount, e.stLen);
            checkEq("R10", "we low during read", weCount, 0);
          end
        end
        csCount = 0; rdCount = 0; weCount = 0; seenCs = -1;
      end
    end
  end

  task automatic writeReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readCheck(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    checkEq(tag, $sformatf("readback @%0h", a), int'(regRdData), int'(exp));
  endtask

  task automatic doAccess(int cs, bit wr, bit pg, logic [15:0] a,
                          int csLen, int stLen, string tag);
    int n;
    expQ.push_back('{cs, csLen, stLen, wr, tag});
    @(negedge clk);
    reqValid = 1'b1; reqCs = 2'(cs); reqWrite = wr; reqPage = pg; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    checkEq("R9", "busy after accept", int'(busy), 1);
    n = 1;
    while (!done) begin
      @(negedge clk);
      n++;
    end
    checkEq("R9", "done cycle", n, ((csLen > stLen) ? csLen : stLen) + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state of outputs
    checkEq("R9", "busy at reset", int'(busy), 0);
    checkEq("R9", "done at reset", int'(done), 0);
    checkEq("R10", "strobes at reset", int'({csN, rdN, weN}), 5'h1F);
    // R1 reset values and unmapped offsets
    readCheck(8'h04, 32'h0101_0101, "R1");
    readCheck(8'h14, 32'h0101_0101, "R1");
    readCheck(8'h24, 32'h0101_0101, "R1");
    readCheck(8'h00, 32'h0, "R1");
    readCheck(8'h34, 32'h0, "R1");
    // R5 default fields give one-cycle pulses
    doAccess(2, 1'b0, 1'b0, 16'h0, 1, 1, "R5");
    // R2 reserved bits masked
    writeReg(8'h04, 32'h8683_8482);
    readCheck(8'h04, 32'h0603_0402, "R2");
    // R3 write under protection ignored
    wrProtect = 1'b1;
    writeReg(8'h04, 32'h7F7F_7F7F);
    wrProtect = 1'b0;
    readCheck(8'h04, 32'h0603_0402, "R3");
    // R5 standard read, R6 write on cs0
    doAccess(0, 1'b0, 1'b0, 16'h0, 6, 3, "R5");
    doAccess(0, 1'b1, 1'b0, 16'h0, 4, 2, "R6");
    // R4 split encoding and zero field on cs1
    writeReg(8'h14, 32'h4100_4005);
    doAccess(1, 1'b0, 1'b0, 16'h0, decLen(7'h41), decLen(7'h00), "R4");
    doAccess(1, 1'b1, 1'b0, 16'h0, decLen(7'h40), decLen(7'h05), "R4");
    // R7 / R8 page mode on cs0 (csRd=6, rd=3)
    doAccess(0, 1'b0, 1'b1, 16'h0012, 6, 6, "R7");
    doAccess(0, 1'b0, 1'b1, 16'h001F, 3, 3, "R7");
    doAccess(0, 1'b0, 1'b1, 16'h0025, 6, 6, "R8");
    doAccess(0, 1'b0, 1'b1, 16'h0026, 3, 3, "R8");
    doAccess(0, 1'b1, 1'b0, 16'h0026, 4, 2, "R6");
    doAccess(0, 1'b0, 1'b1, 16'h0027, 6, 6, "R8");
    doAccess(1, 1'b0, 1'b1, 16'h0027, 257, 257, "R8");
    doAccess(0, 1'b0, 1'b1, 16'h0027, 6, 6, "R8");
    // R9 request while busy is dropped
    expQ.push_back('{1, 256, 5, 1'b1, "R9"});
    @(negedge clk);
    reqValid = 1'b1; reqCs = 2'd1; reqWrite = 1'b1; reqPage = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    reqValid = 1'b1; reqCs = 2'd0; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      checkEq("R9", "busy after dropped request", int'(busy), 0);
    end
    // R9 chip select 3 not accepted
    reqValid = 1'b1; reqCs = 2'd3; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    checkEq("R9", "busy for cs 3", int'(busy), 0);
    checkEq("R10", "cs lines for cs 3", int'(csN), 7);
    checkEq("R9", "pending expectations", expQ.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule